// File: doc/BRIEF.md
# Flash Bad-Block Marker Scanner

This block sweeps a span of erase blocks in a raw flash array and sorts each one into good or bad from the factory marker bytes in its spare area. For every block it asks an external page-read engine for six spare bytes from the first page of that block. It judges those bytes by a rule that depends on the bus width and the page size class, and records the result in an internal bitmap. Each block has a bad bit and a known bit in that bitmap.

A scan is launched with one `start` pulse. The pulse carries the first and last block indices, the page-size class, the bus-width flag and the number of pages per erase block. Bounds outside the array are pulled back into range instead of being refused. One read is outstanding at a time. A read error ends the scan at once. The bitmap can be read at any time through a combinational query port.

Top module: `nand_bbscan`

## Requirements
- R1: After reset `busy`, `done`, `rdReq` and `scanErr` are 0, and every block reads back with `qKnown`=0 and `qBad`=0. After that a known bit is only ever set, never cleared.
- R2: The first request carries page address (clamped first block) × `pagesPerBlock`. Each later request in the same scan carries the previous address plus `pagesPerBlock`, and blocks are visited in ascending order.
- R3: When `wideBus`=1, a block is bad if the bitwise AND of spare byte 0 and spare byte 1 is not 8'hFF. Spare byte k is `rdSpare[8k+7:8k]`. This rule is ORed with the page-size rule (R4/R5).
- R4: When `smallPage`=1 (512-byte pages), a block is bad if spare byte 5 is not 8'hFF.
- R5: When `smallPage`=0 (2048-byte pages), a block is bad if spare byte 0 is not 8'hFF.
- R6: A `firstIdx` that is negative (two's complement) or not below the block count is treated as block 0.
- R7: A `lastIdx` equal to -1, or not below the block count, is treated as the final block. Exactly (last − first + 1) blocks are read when no error occurs.
- R8: If the clamped last index is below the clamped first index (for example any `lastIdx` below -1), no read is issued and `done` rises on the first clock edge after `start`.
- R9: A response with `rdErr`=1 ends the scan. No further request is made, `scanErr` goes to 1 and stays there until the next accepted start, and the failing block's bitmap entry is left untouched.
- R10: `done` is high for exactly one cycle. It rises on the clock edge after the acknowledgement of the last block in range, or after the failing acknowledgement.
- R11: While `rdReq` is high and not yet acknowledged, `rdReq` and `rdPage` hold steady. A `start` that arrives while `busy`=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a scan with the parameters on the inputs below |
| firstIdx | input | IDX_W (8) | Signed first block index |
| lastIdx | input | IDX_W (8) | Signed last block index; -1 selects the final block |
| smallPage | input | 1 | 1 = 512-byte pages, 0 = 2048-byte pages |
| wideBus | input | 1 | 1 = 16-bit flash bus |
| pagesPerBlock | input | PPB_W (16) | Pages in one erase block |
| rdReq | output | 1 | Spare-area read request to the page engine |
| rdPage | output | PAGE_W (24) | Page address of the request |
| rdAck | input | 1 | One-cycle response strobe |
| rdErr | input | 1 | Response carries an error |
| rdSpare | input | 48 | Six spare bytes; byte k at bits 8k+7:8k |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| scanErr | output | 1 | Last scan ended on a read error |
| qIdx | input | BLK_W (6) | Bitmap query index |
| qBad | output | 1 | Bad bit of block `qIdx` |
| qKnown | output | 1 | Known bit of block `qIdx` |

## Verification
The bench targets the clamping corners:
- a negative or oversized first index, which would otherwise start the sweep at a wrong page;
- a last index of -1 or past the end, where an off-by-one would skip or overrun the final block;
- an inverted range, where a broken design would issue a stray read.

It mixes bus widths and page classes with random marker bytes. A design that checks the wrong spare byte, or drops the OR between the bus-width rule and the page-size rule, misclassifies some blocks, and the bitmap read-back exposes this. Read errors are injected in the middle of a range. A design that keeps going past the error, or that marks the failing block as known, shows extra requests or a wrong known bit. A start pulse is also issued mid-scan; if it were accepted, the page sequence would jump.

// File: rtl/bbscan_pkg.sv
package bbscan_pkg;

  localparam int SPARE_BYTES = 6;
  localparam int SPARE_W     = SPARE_BYTES * 8;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // latch clamped bounds and mode
    logic commit;  // store verdict for current block, step forward
    logic fail;    // record read error
  } scan_strobe_t;

endpackage

// File: rtl/bbscan_dp.sv
module bbscan_dp
  import bbscan_pkg::*;
#(
  parameter int NUM_BLOCKS = 64,
  parameter int PAGE_W     = 24,
  parameter int PPB_W      = 16,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int IDX_W     = BLK_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  scan_strobe_t            stb,
  input  logic signed [IDX_W-1:0] firstIdx,
  input  logic signed [IDX_W-1:0] lastIdx,
  input  logic                    smallPage,
  input  logic                    wideBus,
  input  logic [PPB_W-1:0]        pagesPerBlock,
  input  logic [SPARE_W-1:0]      rdSpare,
  input  logic [BLK_W-1:0]        qIdx,
  output logic                    emptyRange,
  output logic                    atLast,
  output logic [PAGE_W-1:0]       rdPage,
  output logic                    scanErr,
  output logic                    qBad,
  output logic                    qKnown
);

  localparam logic signed [IDX_W-1:0] NB_S  = IDX_W'(NUM_BLOCKS);
  localparam logic signed [IDX_W-1:0] TOP_S = IDX_W'(NUM_BLOCKS - 1);

  logic signed [IDX_W-1:0] firstClamp, lastClamp;
  logic [BLK_W-1:0]        curQ, lastQ;
  logic [PAGE_W-1:0]       pageQ;
  logic [PPB_W-1:0]        ppbQ;
  logic                    wideQ, smallQ, errQ;
  logic [NUM_BLOCKS-1:0]   badQ, knownQ;
  logic [7:0]              spareByte [SPARE_BYTES];
  logic                    verdict;

  // bound clamping
  always_comb begin
    if (firstIdx[IDX_W-1] || firstIdx >= NB_S) firstClamp = '0;
    else                                       firstClamp = firstIdx;
    if ((&lastIdx) || lastIdx >= NB_S)         lastClamp  = TOP_S;
    else                                       lastClamp  = lastIdx;
  end
  assign emptyRange = lastClamp < firstClamp;

  // spare byte unpacking
  for (genvar k = 0; k < SPARE_BYTES; k++) begin : g_spare
    assign spareByte[k] = rdSpare[8*k +: 8];
  end

  // marker verdict
  always_comb begin
    verdict = 1'b0;
    if (wideQ && ((spareByte[0] & spareByte[1]) != 8'hFF)) verdict = 1'b1;
    if (smallQ  && (spareByte[5] != 8'hFF))                verdict = 1'b1;
    if (!smallQ && (spareByte[0] != 8'hFF))                verdict = 1'b1;
  end

  assign atLast = (curQ == lastQ);
  assign rdPage = pageQ;
  assign scanErr = errQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curQ   <= '0;
      lastQ  <= '0;
      pageQ  <= '0;
      ppbQ   <= '0;
      wideQ  <= 1'b0;
      smallQ <= 1'b0;
      errQ   <= 1'b0;
    end else if (stb.load) begin
      curQ   <= firstClamp[BLK_W-1:0];
      lastQ  <= lastClamp[BLK_W-1:0];
      pageQ  <= PAGE_W'(firstClamp[BLK_W-1:0]) * PAGE_W'(pagesPerBlock);
      ppbQ   <= pagesPerBlock;
      wideQ  <= wideBus;
      smallQ <= smallPage;
      errQ   <= 1'b0;
    end else if (stb.fail) begin
      errQ   <= 1'b1;
    end else if (stb.commit && !atLast) begin
      curQ   <= curQ + 1'b1;
      pageQ  <= pageQ + PAGE_W'(ppbQ);
    end
  end

  // bad/known bitmap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badQ   <= '0;
      knownQ <= '0;
    end else if (stb.commit) begin
      badQ[curQ]   <= verdict;
      knownQ[curQ] <= 1'b1;
    end
  end

  assign qBad   = badQ[qIdx];
  assign qKnown = knownQ[qIdx];

  // a verdict is only committed for a block inside the clamped range
  assert_commit_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.commit |-> (curQ <= lastQ));

  // known bits never drop once set
  assert_known_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(knownQ)) & ~knownQ) == '0));

endmodule

// File: rtl/bbscan_ctrl.sv
module bbscan_ctrl
  import bbscan_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         emptyRange,
  input  logic         atLast,
  input  logic         rdAck,
  input  logic         rdErr,
  output scan_strobe_t stb,
  output logic         rdReq,
  output logic         busy,
  output logic         done
);

  scan_state_t stateQ;
  logic        doneQ;

  always_comb begin
    stb = '0;
    if (stateQ == ST_IDLE && start) stb.load = 1'b1;
    if (stateQ == ST_SCAN && rdAck) begin
      if (rdErr) stb.fail   = 1'b1;
      else       stb.commit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (stateQ)
        ST_IDLE: if (start) begin
          if (emptyRange) doneQ  <= 1'b1;
          else            stateQ <= ST_SCAN;
        end
        ST_SCAN: if (rdAck && (rdErr || atLast)) begin
          stateQ <= ST_IDLE;
          doneQ  <= 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign rdReq = (stateQ == ST_SCAN);
  assign busy  = (stateQ == ST_SCAN);
  assign done  = doneQ;

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && !rdAck) |=> rdReq);

  assert_no_req_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rdReq);

endmodule

// File: rtl/nand_bbscan.sv
module nand_bbscan
  import bbscan_pkg::*;
#(
  parameter int NUM_BLOCKS = 64,
  parameter int PAGE_W     = 24,
  parameter int PPB_W      = 16,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int IDX_W     = BLK_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [IDX_W-1:0] firstIdx,
  input  logic signed [IDX_W-1:0] lastIdx,
  input  logic                    smallPage,
  input  logic                    wideBus,
  input  logic [PPB_W-1:0]        pagesPerBlock,
  output logic                    rdReq,
  output logic [PAGE_W-1:0]       rdPage,
  input  logic                    rdAck,
  input  logic                    rdErr,
  input  logic [SPARE_W-1:0]      rdSpare,
  output logic                    busy,
  output logic                    done,
  output logic                    scanErr,
  input  logic [BLK_W-1:0]        qIdx,
  output logic                    qBad,
  output logic                    qKnown
);

  scan_strobe_t stb;
  logic         emptyRange, atLast;

  bbscan_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .emptyRange (emptyRange),
    .atLast     (atLast),
    .rdAck      (rdAck),
    .rdErr      (rdErr),
    .stb        (stb),
    .rdReq      (rdReq),
    .busy       (busy),
    .done       (done)
  );

  bbscan_dp #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .PAGE_W     (PAGE_W),
    .PPB_W      (PPB_W)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .stb           (stb),
    .firstIdx      (firstIdx),
    .lastIdx       (lastIdx),
    .smallPage     (smallPage),
    .wideBus       (wideBus),
    .pagesPerBlock (pagesPerBlock),
    .rdSpare       (rdSpare),
    .qIdx          (qIdx),
    .emptyRange    (emptyRange),
    .atLast        (atLast),
    .rdPage        (rdPage),
    .scanErr       (scanErr),
    .qBad          (qBad),
    .qKnown        (qKnown)
  );

  // address from the datapath stays put while the control waits
  assert_page_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && !rdAck) |=> $stable(rdPage));

endmodule

// File: tb/nand_bbscan_tb_top.sv
module nand_bbscan_tb_top;

  localparam int NB = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic signed [7:0] firstIdx = '0;
  logic signed [7:0] lastIdx = '0;
  logic              smallPage = 1'b0;
  logic              wideBus = 1'b0;
  logic [15:0]       pagesPerBlock = 16'd1;
  logic              rdReq;
  logic [23:0]       rdPage;
  logic              rdAck = 1'b0;
  logic              rdErr = 1'b0;
  logic [47:0]       rdSpare = '1;
  logic              busy, done, scanErr;
  logic [5:0]        qIdx = '0;
  logic              qBad, qKnown;

  always #4 clk = ~clk;  // 125 MHz

  nand_bbscan dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .firstIdx(firstIdx), .lastIdx(lastIdx),
    .smallPage(smallPage), .wideBus(wideBus), .pagesPerBlock(pagesPerBlock),
    .rdReq(rdReq), .rdPage(rdPage), .rdAck(rdAck), .rdErr(rdErr), .rdSpare(rdSpare),
    .busy(busy), .done(done), .scanErr(scanErr), .qIdx(qIdx), .qBad(qBad), .qKnown(qKnown)
  );

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 0;

  // reference model state
  bit  mKnown [NB];
  bit  mBad [NB];
  int  expPage, expCur, errAt, readCount, curPpb;
  bit  curWide, curSmall, errSeen, firstReq;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit refBad(input logic [47:0] sp, input bit w, input bit s);
    logic [7:0] b0, b1, b5;
    b0 = sp[7:0]; b1 = sp[15:8]; b5 = sp[47:40];
    return (w && ((b0 & b1) != 8'hFF)) || (s ? (b5 != 8'hFF) : (b0 != 8'hFF));
  endfunction

  function automatic logic [7:0] randMarker();
    if ($urandom % 4 == 0) return 8'($urandom % 256);
    return 8'hFF;
  endfunction

  // page-read responder
  initial begin
    int waitLeft = -1;
    logic [23:0] heldPage = '0;
    forever begin
      @(negedge clk);
      if (rdAck) begin
        rdAck = 1'b0;
        rdErr = 1'b0;
      end else if (rdReq) begin
        if (waitLeft < 0) begin
          waitLeft = int'($urandom % 3);
          heldPage = rdPage;
          chk(int'(rdPage) == expPage, firstReq ? "R6 first page" : "R2 page step",
              rdPage, expPage);
          firstReq = 0;
        end else begin
          chk(rdPage == heldPage, "R11 page held", rdPage, heldPage);
        end
        if (waitLeft == 0) begin
          waitLeft = -1;
          for (int k = 0; k < 6; k++) rdSpare[8*k +: 8] = randMarker();
          readCount++;
          rdAck = 1'b1;
          if (expCur == errAt) begin
            rdErr = 1'b1;
            errSeen = 1;
          end else begin
            rdErr = 1'b0;
            mKnown[expCur] = 1;
            mBad[expCur] = refBad(rdSpare, curWide, curSmall);
          end
          expCur++;
          expPage += curPpb;
        end else begin
          waitLeft--;
        end
      end
    end
  end

  task automatic runScan(input int f, input int l, input bit w, input bit s,
                         input int ppb, input int eAt, input bit poke);
    int fC, lC, expReads, cyc;
    bit expErr;
    fC = (f < 0 || f >= NB) ? 0 : f;
    lC = (l == -1 || l >= NB) ? NB - 1 : l;
    expErr = 0;
    if (lC < fC) expReads = 0;
    else if (eAt >= fC && eAt <= lC) begin expReads = eAt - fC + 1; expErr = 1; end
    else expReads = lC - fC + 1;
    expPage = fC * ppb; expCur = fC; errAt = eAt; readCount = 0;
    curPpb = ppb; curWide = w; curSmall = s; errSeen = 0; firstReq = 1;
    @(negedge clk);
    firstIdx = 8'(f); lastIdx = 8'(l); wideBus = w; smallPage = s;
    pagesPerBlock = 16'(ppb); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      if (busy && !done) begin
        firstIdx = 8'sd7; pagesPerBlock = 16'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0; firstIdx = 8'(f); pagesPerBlock = 16'(ppb);
      end
    end
    cyc = 0;
    if (expReads == 0) begin
      chk(done == 1'b1, "R8 done right after start", done, 1);
      chk(readCount == 0, "R8 no read", readCount, 0);
    end
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R10 done seen", done, 1);
    chk(readCount == expReads, expErr ? "R9 reads before error" : "R7 block count",
        readCount, expReads);
    chk(scanErr == expErr, "R9 error flag", scanErr, expErr);
    if (expErr) chk(rdReq == 1'b0, "R9 no request after error", rdReq, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 single-cycle done", done, 0);
    chk(busy == 1'b0 && rdReq == 1'b0, "R9 idle after scan", {busy, rdReq}, 0);
    for (int b = 0; b < NB; b++) begin
      qIdx = 6'(b);
      #1;
      chk(qKnown == mKnown[b], "R9 known bit", qKnown, mKnown[b]);
      chk(qBad == mBad[b], w ? "R3 verdict" : (s ? "R4 verdict" : "R5 verdict"),
          qBad, mBad[b]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) begin mKnown[b] = 0; mBad[b] = 0; end
    errAt = -1; expPage = 0; expCur = 0; curPpb = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && rdReq == 0 && scanErr == 0, "R1 reset outputs",
        {busy, done, rdReq, scanErr}, 0);
    for (int b = 0; b < NB; b++) begin
      qIdx = 6'(b);
      #1;
      chk(qKnown == 0 && qBad == 0, "R1 bitmap clear", {qKnown, qBad}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // directed corner cases
    runScan(4, 9, 1'b0, 1'b1, 32, -1, 1'b0);    // R4 small page
    runScan(-3, 5, 1'b1, 1'b0, 64, -1, 1'b0);   // R6 negative first, R3 wide
    runScan(100, 3, 1'b0, 1'b0, 4, -1, 1'b0);   // R6 oversized first, R5
    runScan(58, -1, 1'b1, 1'b1, 16, -1, 1'b0);  // R7 last = -1
    runScan(60, 90, 1'b0, 1'b0, 8, -1, 1'b0);   // R7 last past end
    runScan(10, -2, 1'b0, 1'b1, 8, -1, 1'b0);   // R8 negative last
    runScan(20, 5, 1'b1, 1'b0, 8, -1, 1'b0);    // R8 inverted range
    runScan(30, 40, 1'b0, 1'b1, 2, 34, 1'b0);   // R9 mid-range error
    runScan(0, 63, 1'b1, 1'b0, 1, -1, 1'b1);    // R11 start while busy
    // constrained random
    for (int n = 0; n < 40; n++) begin
      int f, l, e;
      f = int'($urandom % 80) - 8;
      l = ($urandom % 6 == 0) ? -1 : int'($urandom % 80) - 8;
      e = ($urandom % 5 == 0) ? int'($urandom % NB) : -1;
      runScan(f, l, 1'($urandom), 1'($urandom), int'($urandom % 40) + 1, e, 1'b0);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule